// File: doc/BRIEF.md
# Even-Ratio Clock Divider

This block takes one input clock and produces a slower clock whose frequency is the input frequency divided by an even ratio between 2 and 16. The ratio is picked at run time through a 3-bit code. At every ratio the output spends exactly as many input cycles high as low, so the divided clock has a 50% duty cycle. A typical use is a half-rate clock net whose loads are registers that capture on both edges, which restores the full effective rate while the net itself toggles at half speed.

The divider is built so that it never emits a shortened (runt) high or low phase. A new ratio code is picked up only at the falling edge of the output, where one full period ends. The synchronous reset drives the output low and restarts the phase counter. If reset arrives while the output is high, the high phase still runs to its full length before the output is held low. The output is the output of a flip-flop and is not decoded from several state bits.

The controller has three states. HOLD is the reset state and keeps the output low. LOW is the counted low phase and HIGH is the counted high phase. The transitions are: HOLD to HOLD while reset is high. HOLD to HIGH on release when the code is 0. HOLD to LOW on release for any other code. LOW to HOLD on reset. LOW to HIGH when the phase count ends. HIGH to LOW when the phase count ends with reset low. HIGH to HOLD when the phase count ends with reset high. When power first comes up, reset should be held for at least 2^SEL_W + 1 cycles so that any high phase in progress can finish.

Top module: `clk_even_div`

## Requirements
- R1: A ratio code c in the range 0 to 7 selects division by 2·(c+1), so codes 0 through 7 give ratios 2, 4, 6, 8, 10, 12, 14 and 16.
- R2: On a rising edge where rst is 1 and the output is low, the output stays low after that edge. The phase counter restarts, and the ratio code on `ratio_sel` at that edge becomes the active code.
- R3: After the last rising edge that samples rst at 1, the output stays low for exactly c+1 input cycles and then rises, where c is the active code.
- R4: While the ratio stays the same, every high phase and every low phase lasts c+1 input cycles, giving a period of 2·(c+1) cycles.
- R5: `ratio_sel` is sampled only on the edge where the output falls (and on reset edges). A change at any other time does not alter the current low or high phase, and the new code sets the length of both phases of the next period.
- R6: If rst is sampled high while the output is high, the high phase still lasts its full c+1 cycles. The output is then held low if rst is still high at the edge that ends the phase. A reset pulse that ends before the high phase ends has no effect on the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock to be divided |
| rst | input | 1 | Synchronous reset, active high |
| ratio_sel | input | SEL_W (3) | Ratio code c; division ratio is 2·(c+1) |
| clk_div | output | 1 | Divided clock, 50% duty cycle, driven by a flip-flop |

## Verification
The hardest cases to reach from the ports are a reset or a ratio change that lands in the middle of a phase. A reset that starts during a high phase is the critical one, because that is where a runt pulse could appear. The stimulus first synchronises to the output by counting its low and high runs. It then raises reset, or changes the code, a set number of cycles into a known phase, either for a single edge or held over the phase boundary. Run lengths are then measured on both sides of the event. A behavioural model that tracks remaining phase cycles is compared against the output on every cycle.

// File: rtl/clk_even_div_pkg.sv
package clk_even_div_pkg;

    // Bit 0 of the state is the divided clock itself, so the output
    // is taken straight from a flip-flop and never decoded.
    typedef enum logic [1:0] {
        PH_HOLD = 2'b00,
        PH_LOW  = 2'b10,
        PH_HIGH = 2'b01
    } phase_t;

endpackage

// File: rtl/clk_even_div_ratio.sv
// Holds the ratio code in force; it is reloaded only when the
// controller says a full period is over or reset is being honoured.
module clk_even_div_ratio #(
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             load,
    input  logic [SEL_W-1:0] code_in,
    output logic [SEL_W-1:0] code_q
);

    always_ff @(posedge clk) begin
        if (load) begin
            code_q <= code_in;
        end
    end

endmodule

// File: rtl/clk_even_div_count.sv
// Phase counter: counts input cycles inside one phase and flags the
// last cycle of that phase, which lasts (limit + 1) cycles.
module clk_even_div_count #(
    parameter int SEL_W = 3,
    localparam int CNT_W = SEL_W
) (
    input  logic             clk,
    input  logic             clr,
    input  logic [SEL_W-1:0] limit,
    output logic             last
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (clr) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    always_comb begin
        last = (cnt_q == limit);
    end

endmodule

// File: rtl/clk_even_div_fsm.sv
// Phase controller: HOLD, LOW and HIGH, with the output on a state bit.
module clk_even_div_fsm
    import clk_even_div_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic last,
    output logic cnt_clr,
    output logic code_load,
    output logic div_o
);

    phase_t state_q;
    phase_t state_d;

    // State register. Reset is synchronous and enters through the
    // next-state logic, so an open high phase can finish first.
    always_ff @(posedge clk) begin
        state_q <= state_d;
    end

    // Next-state logic plus counter and ratio controls.
    always_comb begin
        state_d   = state_q;
        cnt_clr   = 1'b0;
        code_load = 1'b0;
        unique case (state_q)
            PH_HOLD: begin
                if (rst) begin
                    cnt_clr   = 1'b1;
                    code_load = 1'b1;
                end else if (last) begin
                    state_d = PH_HIGH;
                    cnt_clr = 1'b1;
                end else begin
                    state_d = PH_LOW;
                end
            end
            PH_LOW: begin
                if (rst) begin
                    state_d   = PH_HOLD;
                    cnt_clr   = 1'b1;
                    code_load = 1'b1;
                end else if (last) begin
                    state_d = PH_HIGH;
                    cnt_clr = 1'b1;
                end
            end
            PH_HIGH: begin
                // Reset is not acted on until the high phase is complete.
                if (last) begin
                    state_d   = rst ? PH_HOLD : PH_LOW;
                    cnt_clr   = 1'b1;
                    code_load = 1'b1;
                end
            end
            default: begin
                state_d   = PH_HOLD;
                cnt_clr   = 1'b1;
                code_load = 1'b1;
            end
        endcase
    end

    // Output process: the divided clock is the HIGH bit of the state.
    always_comb begin
        div_o = state_q[0];
    end

endmodule

// File: rtl/clk_even_div.sv
module clk_even_div #(
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [SEL_W-1:0] ratio_sel,
    output logic             clk_div
);

    logic             cnt_clr;
    logic             code_load;
    logic             last;
    logic [SEL_W-1:0] act_code;

    clk_even_div_ratio #(.SEL_W(SEL_W)) u_ratio (
        .clk     (clk),
        .load    (code_load),
        .code_in (ratio_sel),
        .code_q  (act_code)
    );

    clk_even_div_count #(.SEL_W(SEL_W)) u_count (
        .clk   (clk),
        .clr   (cnt_clr),
        .limit (act_code),
        .last  (last)
    );

    clk_even_div_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .last      (last),
        .cnt_clr   (cnt_clr),
        .code_load (code_load),
        .div_o     (clk_div)
    );

endmodule

// File: rtl/clk_even_div_chk.sv
module clk_even_div_chk #(
    parameter int SEL_W = 3,
    localparam int LEN_W = SEL_W + 2
) (
    input logic             clk,
    input logic             rst,
    input logic             clk_div,
    input logic [SEL_W-1:0] act_code
);

    logic             started = 1'b0;
    logic             prev_q;
    logic [LEN_W-1:0] lo_len;
    logic [LEN_W-1:0] hi_len;
    logic [SEL_W-1:0] rise_code;

    always_ff @(posedge clk) begin
        started <= started | rst;
        prev_q  <= clk_div;
        if (rst || clk_div) begin
            lo_len <= '0;
        end else if (lo_len != {LEN_W{1'b1}}) begin
            lo_len <= lo_len + 1'b1;
        end
        if (!clk_div) begin
            hi_len <= '0;
        end else if (hi_len != {LEN_W{1'b1}}) begin
            hi_len <= hi_len + 1'b1;
        end
        if (clk_div && !prev_q) begin
            rise_code <= act_code;
        end
    end

    // R2: a low output with reset sampled stays low.
    assert_reset_low_R2: assert property (@(posedge clk) disable iff (!started)
        (rst && !clk_div) |=> !clk_div);

    // R3 and R4: each low phase outside reset lasts code+1 cycles.
    assert_low_len_R3: assert property (@(posedge clk) disable iff (rst || !started)
        $rose(clk_div) |-> (lo_len == LEN_W'(act_code) + 1'b1));

    // R6 (and R4): every high phase lasts code+1 cycles, even across reset.
    assert_high_len_R6: assert property (@(posedge clk) disable iff (!started)
        $fell(clk_div) |-> (hi_len == LEN_W'(rise_code) + 1'b1));

    // R5: the active code only moves at a falling edge or out of reset.
    assert_code_hold_R5: assert property (@(posedge clk) disable iff (rst || !started)
        (!$fell(clk_div) && !$past(rst)) |-> $stable(act_code));

endmodule

bind clk_even_div clk_even_div_chk #(.SEL_W(SEL_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .clk_div  (clk_div),
    .act_code (act_code)
);

// File: tb/clk_even_div_test.sv
module clk_even_div_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] ratio_sel = 3'd0;
    logic       clk_div;

    int total = 0;
    int bad = 0;
    int cycles = 0;
    bit model_on = 1'b0;
    string cur_req = "R2";

    // Behavioural reference: level, cycles left in phase, half length.
    int ref_lvl = 0;
    int ref_left = 0;
    int ref_half = 1;
    bit ref_hold = 1'b1;

    clk_even_div uut (
        .clk       (clk),
        .rst       (rst),
        .ratio_sel (ratio_sel),
        .clk_div   (clk_div)
    );

    always #5 clk = ~clk;

    task automatic check(input bit ok, input string req, input int got, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: got %0d expected %0d (t=%0t)", req, got, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            bad++;
            total++;
            $display("FAIL watchdog: got %0d cycles expected fewer", cycles);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
        if (ref_lvl == 1) begin
            ref_left--;
            if (ref_left == 0) begin
                ref_half = int'(ratio_sel) + 1;
                ref_lvl  = 0;
                if (rst) ref_hold = 1'b1;
                else ref_left = ref_half;
            end
        end else if (rst) begin
            ref_hold = 1'b1;
            ref_half = int'(ratio_sel) + 1;
        end else if (ref_hold) begin
            ref_hold = 1'b0;
            ref_left = ref_half - 1;
            if (ref_left == 0) begin
                ref_lvl  = 1;
                ref_left = ref_half;
            end
        end else begin
            ref_left--;
            if (ref_left == 0) begin
                ref_lvl  = 1;
                ref_left = ref_half;
            end
        end
    end

    always @(negedge clk) begin
        if (model_on) begin
            check(int'(clk_div) == ref_lvl, {cur_req, " model"}, int'(clk_div), ref_lvl);
        end
    end

    // Called at a negedge: counts samples while the output holds lvl.
    task automatic run_len(input logic lvl, output int n);
        n = 0;
        while (clk_div === lvl && n < 100) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic restart(input int code);
        @(negedge clk);
        ratio_sel = 3'(code);
        rst = 1'b1;
        repeat (20) @(negedge clk);
        check(clk_div === 1'b0, "R2 low in reset", int'(clk_div), 0);
        rst = 1'b0;
    endtask

    initial begin
        int n;
        repeat (20) @(negedge clk);
        check(clk_div === 1'b0, "R2 reset state", int'(clk_div), 0);
        model_on = 1'b1;

        // R1, R3, R4: every code, first low run then steady phases.
        for (int c = 0; c < 8; c++) begin
            cur_req = "R4";
            restart(c);
            run_len(1'b0, n);
            check(n == c + 1, "R3 first low run", n, c + 1);
            run_len(1'b1, n);
            check(n == c + 1, "R4 high run", n, c + 1);
            run_len(1'b0, n);
            check(n == c + 1, "R4 low run", n, c + 1);
            run_len(1'b1, n);
            check(2 * n == 2 * (c + 1), "R1 ratio", 2 * n, 2 * (c + 1));
        end

        // R5: code change in a high phase, then in a low phase.
        cur_req = "R5";
        restart(3);
        run_len(1'b0, n);
        @(negedge clk);
        ratio_sel = 3'd6;
        run_len(1'b1, n);
        check(n == 3, "R5 rest of high kept", n, 3);
        run_len(1'b0, n);
        check(n == 7, "R5 new low", n, 7);
        run_len(1'b1, n);
        check(n == 7, "R5 new high", n, 7);
        @(negedge clk);
        ratio_sel = 3'd1;
        run_len(1'b0, n);
        check(n == 6, "R5 rest of low kept", n, 6);
        run_len(1'b1, n);
        check(n == 7, "R5 high of old period", n, 7);
        run_len(1'b0, n);
        check(n == 2, "R5 low after switch", n, 2);
        run_len(1'b1, n);
        check(n == 2, "R5 high after switch", n, 2);

        // R6: reset raised two samples into a high phase, then held.
        cur_req = "R6";
        restart(5);
        run_len(1'b0, n);
        @(negedge clk);
        rst = 1'b1;
        run_len(1'b1, n);
        check(n == 5, "R6 high finishes under reset", n, 5);
        repeat (10) @(negedge clk);
        check(clk_div === 1'b0, "R6 held low", int'(clk_div), 0);
        rst = 1'b0;
        run_len(1'b0, n);
        check(n == 6, "R3 low after drained reset", n, 6);

        // R6: a one-edge reset pulse inside a high phase is ignored.
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        run_len(1'b1, n);
        check(n == 4, "R6 short pulse high", n, 4);
        run_len(1'b0, n);
        check(n == 6, "R6 short pulse low", n, 6);

        // R2: reset inside a low phase keeps the output low at once.
        cur_req = "R2";
        @(negedge clk);
        while (clk_div !== 1'b0) @(negedge clk);
        @(negedge clk);
        rst = 1'b1;
        ratio_sel = 3'd2;
        @(negedge clk);
        check(clk_div === 1'b0, "R2 low on reset", int'(clk_div), 0);
        rst = 1'b0;
        run_len(1'b0, n);
        check(n == 3, "R2 code taken at reset", n, 3);
        run_len(1'b1, n);
        check(n == 3, "R4 high after reset", n, 3);

        repeat (4) @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule